// File: doc/BRIEF.md
# Transmit Descriptor Sequencer with Frame Rewind

This block steers a transmit DMA around a ring of buffer descriptors. A single frame may take up several consecutive descriptors. A start strobe arms the engine. The block then reads one descriptor at a time through a request/response port. For each buffer it finds, it issues one fetch command to a data mover. A descriptor whose used flag is set marks the point where software has not refilled the ring.

At the start of every frame the block records the descriptor index where that frame began.

- **Collision:** a collision reported while a buffer is moving makes the block jump back to that recorded index and send the frame again. Software takes no part in this.
- **Used flag partway through a frame:** this counts as a transmit error. The engine stops and emits a one-cycle error pulse. It also holds a corrupt-FCS request towards the MAC until the MAC acknowledges the end of the frame. The descriptor pointer is left at the frame's first index, so the next start sends the whole frame again.
- **Used flag on the first descriptor of a frame:** this is the normal end of queued work. The engine stops with a one-cycle used-read pulse.
- **Halt request:** a halt is remembered and honoured only at a frame boundary.

States:

- **ST_IDLE:** waiting for the transmit-go flag.
- **ST_DREQ:** a descriptor request is outstanding.
- **ST_XFER:** a buffer fetch command is outstanding.

Transitions:

- **IDLE→DREQ:** go set and no halt pending.
- **IDLE→IDLE:** a pending halt clears go.
- **DREQ→XFER:** a descriptor comes back with its used flag clear.
- **DREQ→IDLE:** one of three causes:
  - a used flag on the first descriptor of a frame (used-read pulse);
  - a used flag inside a frame (error, rewind);
  - a pending halt with no frame open.
- **XFER→DREQ:** one of three causes:
  - a buffer completes that is not the frame's last;
  - the last buffer completes with no halt pending;
  - a collision (rewind).
- **XFER→IDLE:** the last buffer of a frame completes while a halt is pending.

Top module: `txd_seq`

## Requirements
- R1: After reset, go_o, desc_req_o, fetch_valid_o, err_pulse_o, used_read_o and bad_fcs_o are 0, and desc_idx_o is 0.
- R2: A one-cycle start_i pulse sets go_o at the next clock edge. While go_o is set, the block requests the descriptor at desc_idx_o.
- R3: For each descriptor returned with its used flag at 0, the block issues a single fetch command. The command carries that descriptor's address and length, and fetch_last_o equals the descriptor's end-of-frame flag. fetch_valid_o is only asserted while go_o is 1.
- R4: After each completed buffer the pointer moves to the next descriptor. After index RING-1 it wraps to index 0.
- R5: A used flag on the first descriptor of a frame issues no fetch and leaves desc_idx_o unchanged. It clears go_o and pulses used_read_o for exactly one cycle.
- R6: A used flag on a later descriptor of a frame has four effects:
  - err_pulse_o pulses for exactly one cycle;
  - go_o clears;
  - desc_idx_o returns to the frame's first index;
  - bad_fcs_o rises and stays at 1 until frame_end_ack_i.
- R7: After an error stop, a new start_i resumes with the first descriptor of the interrupted frame.
- R8: A collision_i during a buffer fetch restarts the frame from its first descriptor without a new start_i. go_o stays at 1.
- R9: A halt_i received during a frame takes effect only after that frame's last buffer completes. The block then clears go_o and makes no further descriptor requests. A later start_i resumes at the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe from the control register |
| halt_i | input | 1 | Halt request strobe |
| desc_req_o | output | 1 | Descriptor read request |
| desc_idx_o | output | IDX_W | Ring index of the requested descriptor |
| desc_ack_i | input | 1 | Descriptor response valid |
| desc_addr_i | input | AW | Buffer address from the descriptor |
| desc_len_i | input | LW | Buffer length from the descriptor |
| desc_used_i | input | 1 | Used flag from the descriptor |
| desc_eof_i | input | 1 | End-of-frame flag from the descriptor |
| fetch_valid_o | output | 1 | Buffer fetch command valid, held until done or collision |
| fetch_addr_o | output | AW | Buffer address to fetch |
| fetch_len_o | output | LW | Buffer length to fetch |
| fetch_last_o | output | 1 | Buffer is the last of its frame |
| fetch_done_i | input | 1 | Data mover finished the buffer |
| collision_i | input | 1 | Collision indication from the MAC |
| frame_end_ack_i | input | 1 | MAC acknowledges the end of the frame |
| go_o | output | 1 | Transmit-go status |
| err_pulse_o | output | 1 | One-cycle transmit error pulse |
| used_read_o | output | 1 | One-cycle used-flag-read status pulse |
| bad_fcs_o | output | 1 | Request to the MAC to corrupt the FCS |

## Verification
The main path is driven with three ring layouts:

- single-buffer frames;
- frames of two and three buffers;
- a frame that crosses the ring end.

Together these separate correct pointer advance from a missed wrap or a skipped descriptor.

The directed cases follow:

- A used flag in the middle of a frame must rewind and raise the error, whereas a used flag at a frame start must only stop.
- A collision on the second buffer must replay both buffers.
- A halt seen during the first buffer must still let the frame finish.

Each of these distinguishes boundary handling from plain advance.

// File: rtl/txd_pkg.sv
package txd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DREQ,
        ST_XFER
    } txd_state_t;
endpackage

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr #(
    parameter int RING  = 8,
    parameter int IDX_W = (RING > 1) ? $clog2(RING) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             mark,
    input  logic             rewind,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] first_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(RING - 1);

    logic [IDX_W-1:0] cur_q, first_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= '0;
            first_q <= '0;
        end else begin
            if (rewind)
                cur_q <= first_q;
            else if (adv)
                cur_q <= (cur_q == LAST) ? '0 : cur_q + 1'b1;
            if (mark)
                first_q <= cur_q;
        end
    end

    assign cur_idx   = cur_q;
    assign first_idx = first_q;

    // R4: wrap after the last ring entry
    a_r4_ring_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !rewind && cur_q == LAST) |=> (cur_q == '0));
endmodule

// File: rtl/txd_err_track.sv
module txd_err_track (
    input  logic clk,
    input  logic rst_n,
    input  logic err_set,
    input  logic used_hit,
    input  logic frame_end_ack,
    output logic err_pulse,
    output logic used_pulse,
    output logic bad_fcs
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_pulse  <= 1'b0;
            used_pulse <= 1'b0;
            bad_fcs    <= 1'b0;
        end else begin
            err_pulse  <= err_set;
            used_pulse <= used_hit;
            if (err_set)
                bad_fcs <= 1'b1;
            else if (frame_end_ack)
                bad_fcs <= 1'b0;
        end
    end

    // R6: error status lasts one cycle
    a_r6_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);
    // R6: corrupt-FCS request held until acknowledged
    a_r6_fcs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_fcs && !frame_end_ack) |=> bad_fcs);
    // R5: used-read status lasts one cycle
    a_r5_used_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        used_pulse |=> !used_pulse);
endmodule

// File: rtl/txd_seq.sv
module txd_seq
    import txd_pkg::*;
#(
    parameter int RING  = 8,
    parameter int AW    = 32,
    parameter int LW    = 14,
    parameter int IDX_W = (RING > 1) ? $clog2(RING) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             halt_i,
    output logic             desc_req_o,
    output logic [IDX_W-1:0] desc_idx_o,
    input  logic             desc_ack_i,
    input  logic [AW-1:0]    desc_addr_i,
    input  logic [LW-1:0]    desc_len_i,
    input  logic             desc_used_i,
    input  logic             desc_eof_i,
    output logic             fetch_valid_o,
    output logic [AW-1:0]    fetch_addr_o,
    output logic [LW-1:0]    fetch_len_o,
    output logic             fetch_last_o,
    input  logic             fetch_done_i,
    input  logic             collision_i,
    input  logic             frame_end_ack_i,
    output logic             go_o,
    output logic             err_pulse_o,
    output logic             used_read_o,
    output logic             bad_fcs_o
);
    txd_state_t st_q, st_d;

    logic             go_q, halt_pend_q, in_frame_q, in_frame_d;
    logic [AW-1:0]    addr_q;
    logic [LW-1:0]    len_q;
    logic             eof_q;
    logic             ptr_adv, ptr_mark, ptr_rew;
    logic             go_clr, err_set, used_hit, halt_done, buf_load;
    logic [IDX_W-1:0] cur_idx, first_idx;

    // State and frame-tracking registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            go_q        <= 1'b0;
            halt_pend_q <= 1'b0;
            in_frame_q  <= 1'b0;
            addr_q      <= '0;
            len_q       <= '0;
            eof_q       <= 1'b0;
        end else begin
            st_q       <= st_d;
            in_frame_q <= in_frame_d;
            if (go_clr)
                go_q <= 1'b0;
            else if (start_i)
                go_q <= 1'b1;
            if (halt_i)
                halt_pend_q <= 1'b1;
            else if (halt_done || start_i)
                halt_pend_q <= 1'b0;
            if (buf_load) begin
                addr_q <= desc_addr_i;
                len_q  <= desc_len_i;
                eof_q  <= desc_eof_i;
            end
        end
    end

    // Next state and control
    always_comb begin
        st_d       = st_q;
        in_frame_d = in_frame_q;
        ptr_adv    = 1'b0;
        ptr_mark   = 1'b0;
        ptr_rew    = 1'b0;
        go_clr     = 1'b0;
        err_set    = 1'b0;
        used_hit   = 1'b0;
        halt_done  = 1'b0;
        buf_load   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (halt_pend_q) begin
                    go_clr    = 1'b1;
                    halt_done = 1'b1;
                end else if (go_q) begin
                    st_d = ST_DREQ;
                end
            end
            ST_DREQ: begin
                if (halt_pend_q && !in_frame_q) begin
                    go_clr    = 1'b1;
                    halt_done = 1'b1;
                    st_d      = ST_IDLE;
                end else if (desc_ack_i) begin
                    if (desc_used_i) begin
                        st_d   = ST_IDLE;
                        go_clr = 1'b1;
                        if (in_frame_q) begin
                            err_set    = 1'b1;
                            ptr_rew    = 1'b1;
                            in_frame_d = 1'b0;
                        end else begin
                            used_hit = 1'b1;
                        end
                    end else begin
                        buf_load   = 1'b1;
                        ptr_mark   = !in_frame_q;
                        in_frame_d = 1'b1;
                        st_d       = ST_XFER;
                    end
                end
            end
            ST_XFER: begin
                if (collision_i) begin
                    ptr_rew    = 1'b1;
                    in_frame_d = 1'b0;
                    st_d       = ST_DREQ;
                end else if (fetch_done_i) begin
                    ptr_adv = 1'b1;
                    st_d    = ST_DREQ;
                    if (eof_q) begin
                        in_frame_d = 1'b0;
                        if (halt_pend_q) begin
                            go_clr    = 1'b1;
                            halt_done = 1'b1;
                            st_d      = ST_IDLE;
                        end
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    txd_ring_ptr #(.RING(RING), .IDX_W(IDX_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (ptr_adv),
        .mark      (ptr_mark),
        .rewind    (ptr_rew),
        .cur_idx   (cur_idx),
        .first_idx (first_idx)
    );

    txd_err_track u_err (
        .clk           (clk),
        .rst_n         (rst_n),
        .err_set       (err_set),
        .used_hit      (used_hit),
        .frame_end_ack (frame_end_ack_i),
        .err_pulse     (err_pulse_o),
        .used_pulse    (used_read_o),
        .bad_fcs       (bad_fcs_o)
    );

    assign desc_req_o    = (st_q == ST_DREQ);
    assign desc_idx_o    = cur_idx;
    assign fetch_valid_o = (st_q == ST_XFER);
    assign fetch_addr_o  = addr_q;
    assign fetch_len_o   = len_q;
    assign fetch_last_o  = eof_q;
    assign go_o          = go_q;

    // R3: no fetch command without transmit-go
    a_r3_fetch_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid_o |-> go_o);
    // R5: used flag at a frame start stops the engine
    a_r5_used_stops: assert property (@(posedge clk) disable iff (!rst_n)
        used_read_o |-> (!go_o && !desc_req_o && !fetch_valid_o));
    // R6: an error leaves the engine stopped with corrupt FCS requested
    a_r6_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |-> (bad_fcs_o && !go_o));
    // R8: collision re-requests the frame's first descriptor
    a_r8_collision_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_o && collision_i) |=> (desc_req_o && go_o && desc_idx_o == $past(first_idx)));
endmodule

// File: tb/sim_txd_seq.sv
module sim_txd_seq;
    localparam int RING = 8;
    localparam int AW = 32;
    localparam int LW = 14;
    localparam int IDX_W = 3;
    // main run: {last, idx} expected per fetch
    localparam logic [3:0] VEC [6] = '{4'b1000, 4'b0001, 4'b1010, 4'b0011, 4'b0100, 4'b1101};

    logic clk = 0, rst_n = 0;
    logic start_i = 0, halt_i = 0;
    logic desc_ack_i = 0, desc_used_i = 0, desc_eof_i = 0;
    logic [AW-1:0] desc_addr_i = '0;
    logic [LW-1:0] desc_len_i = '0;
    logic fetch_done_i = 0, collision_i = 0, frame_end_ack_i = 0;
    logic desc_req_o, fetch_valid_o, fetch_last_o, go_o, err_pulse_o, used_read_o, bad_fcs_o;
    logic [IDX_W-1:0] desc_idx_o;
    logic [AW-1:0] fetch_addr_o;
    logic [LW-1:0] fetch_len_o;

    int nchk = 0, nerr = 0;
    int err_cnt = 0, used_cnt = 0, fcount = 0, coll_on = -1;
    int flog [64];
    logic flast [64];
    logic d_used [RING];
    logic d_eof [RING];

    txd_seq #(.RING(RING), .AW(AW), .LW(LW)) u0 (.*);

    always #4 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // descriptor ring and data mover model
    always @(negedge clk) begin
        if (rst_n) begin
            logic busy;
            if (err_pulse_o) err_cnt++;
            if (used_read_o) used_cnt++;
            if (desc_req_o && !desc_ack_i) begin
                desc_ack_i  = 1;
                desc_addr_i = 32'h1000 + 32'(desc_idx_o) * 256;
                desc_len_i  = LW'(64 + int'(desc_idx_o));
                desc_used_i = d_used[desc_idx_o];
                desc_eof_i  = d_eof[desc_idx_o];
            end else begin
                desc_ack_i = 0;
            end
            busy = fetch_done_i | collision_i;
            fetch_done_i = 0;
            collision_i  = 0;
            if (fetch_valid_o && !busy) begin
                int ix;
                ix = int'((fetch_addr_o - 32'h1000) >> 8);
                chk("R3 len", int'(fetch_len_o), 64 + ix);
                if (fcount < 64) begin
                    flog[fcount]  = ix;
                    flast[fcount] = fetch_last_o;
                end
                if (fcount == coll_on) begin
                    collision_i = 1;
                    coll_on = -1;
                end else begin
                    fetch_done_i = 1;
                end
                fcount++;
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_i = 1;
        @(negedge clk) start_i = 0;
    endtask

    task automatic wait_stop(string req);
        int n = 0;
        while ((go_o || desc_req_o || fetch_valid_o) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 2000) chk({req, " watchdog"}, 1, 0);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        chk("watchdog", 1, 0);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        int base;
        for (int i = 0; i < RING; i++) d_used[i] = 0;
        d_used[6] = 1;
        d_eof[0] = 1; d_eof[1] = 0; d_eof[2] = 1; d_eof[3] = 0;
        d_eof[4] = 0; d_eof[5] = 1; d_eof[6] = 0; d_eof[7] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 go", int'(go_o), 0);
        chk("R1 req", int'(desc_req_o), 0);
        chk("R1 fetch", int'(fetch_valid_o), 0);
        chk("R1 idx", int'(desc_idx_o), 0);
        chk("R1 fcs", int'(bad_fcs_o), 0);
        chk("R1 err", int'(err_pulse_o | used_read_o), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R2 / R3 / R4 / R5 main run from the vector table
        pulse_start();
        chk("R2 go set", int'(go_o), 1);
        wait_stop("R3");
        chk("R3 fetch count", fcount, 6);
        for (int i = 0; i < 6; i++) begin
            chk("R4 order", flog[i], int'(VEC[i][2:0]));
            chk("R3 last", int'(flast[i]), int'(VEC[i][3]));
        end
        chk("R5 used pulse", used_cnt, 1);
        chk("R5 idx kept", int'(desc_idx_o), 6);
        chk("R5 go cleared", int'(go_o), 0);
        chk("R5 no error", err_cnt, 0);

        // R4 wrap across the ring end
        d_used[6] = 0; d_used[7] = 0; d_used[1] = 1;
        base = fcount;
        pulse_start();
        wait_stop("R4");
        chk("R4 wrap count", fcount - base, 3);
        chk("R4 wrap a", flog[base], 6);
        chk("R4 wrap b", flog[base + 1], 7);
        chk("R4 wrap c", flog[base + 2], 0);
        chk("R4 idx", int'(desc_idx_o), 1);

        // R6 used flag in the middle of a frame
        d_used[1] = 0; d_eof[1] = 0; d_used[2] = 1;
        base = fcount;
        pulse_start();
        wait_stop("R6");
        chk("R6 fetches", fcount - base, 1);
        chk("R6 err one pulse", err_cnt, 1);
        chk("R6 go", int'(go_o), 0);
        chk("R6 rewind idx", int'(desc_idx_o), 1);
        chk("R6 used not counted", used_cnt, 2);
        repeat (5) @(negedge clk);
        chk("R6 fcs held", int'(bad_fcs_o), 1);
        frame_end_ack_i = 1;
        @(negedge clk) frame_end_ack_i = 0;
        chk("R6 fcs released", int'(bad_fcs_o), 0);

        // R7 restart resumes at the frame's first descriptor
        d_used[2] = 0; d_eof[2] = 1; d_used[3] = 1;
        base = fcount;
        pulse_start();
        wait_stop("R7");
        chk("R7 fetches", fcount - base, 2);
        chk("R7 first", flog[base], 1);
        chk("R7 idx", int'(desc_idx_o), 3);

        // R8 collision on the second buffer of a frame
        d_used[3] = 0; d_eof[3] = 0; d_eof[4] = 1; d_used[5] = 1;
        base = fcount;
        coll_on = base + 1;
        pulse_start();
        wait_stop("R8");
        chk("R8 fetches", fcount - base, 4);
        chk("R8 replay a", flog[base + 2], 3);
        chk("R8 replay b", flog[base + 3], 4);
        chk("R8 no error", err_cnt, 1);
        chk("R8 idx", int'(desc_idx_o), 5);

        // R9 halt during a frame waits for its end
        d_used[5] = 0; d_eof[5] = 0; d_eof[6] = 0; d_eof[7] = 1;
        d_used[0] = 0; d_eof[0] = 1; d_used[1] = 1;
        base = fcount;
        pulse_start();
        while (fcount == base) @(negedge clk);
        halt_i = 1;
        @(negedge clk) halt_i = 0;
        wait_stop("R9");
        chk("R9 frame finished", fcount - base, 3);
        chk("R9 idx", int'(desc_idx_o), 0);
        chk("R9 go", int'(go_o), 0);
        base = fcount;
        pulse_start();
        wait_stop("R9 resume");
        chk("R9 resume fetch", fcount - base, 1);
        chk("R9 resume idx", flog[base], 0);

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule